// File: doc/BRIEF.md
# Clutter Map CFAR Detector

The block flags radar returns that stand out from the clutter normally seen in their own range cell. It keeps one background word per range cell in on-chip RAM. That word is a first-order recursive average of the cell's past samples, built up scan by scan. Neighbouring cells in the current sweep play no part in it.

Each accepted sample reads its cell's stored background. The block scales that background by a programmable multiplier to form a threshold and compares the sample against it. It then blends the sample into the background with programmable new/old weights and writes the result back. The comparison always uses the background as it stood before the current sample, so a target cannot raise its own threshold.

One sample can be accepted on every clock. After reset, or after a clear pulse, a sweep zeroes the whole map. Detections then stay muted until one complete scan has been accumulated.

Top module: `cmap_cfar`

## Requirements
- R1: After reset release or a one-cycle `clear_i` pulse, the block spends NCELLS cycles zeroing every stored estimate. Strobes arriving in that window produce no output and change no estimate.
- R2: Each accepted strobe produces exactly one result, with `out_valid_o` high two clock cycles after the strobe cycle. `out_idx_o` carries the strobe's range index, and results come out in input order.
- R3: `thr_o` = min(floor(`thr_mult_i` × old / 2^16), 65535). Here old is the cell's estimate before this sample, and `thr_mult_i` is unsigned with 16 fraction bits and 4 integer bits.
- R4: `hit_o` is 1 only when the sample is strictly greater than `thr_o`. A sample equal to the threshold gives no hit.
- R5: `est_o` = min(floor(`gain_new_i` × sample / 2^16) + floor(`gain_old_i` × old / 2^16), 65535). This value is written back as the cell's estimate. Both gains are unsigned 16-bit fractions, so 0.1 / 0.9 is 6554 / 58982.
- R6: Strobes to the same range index on consecutive cycles each see the estimate left by the one before.
- R7: After the clearing sweep, `hit_o` is forced to 0 until the second accepted strobe that has `scan_start_i` = 1. That second strobe and all later ones may raise a hit.
- R8: A cycle with `sample_valid_i` low leaves every estimate unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; starts a clearing sweep |
| clear_i | input | 1 | Synchronous request to zero the whole map |
| sample_valid_i | input | 1 | Sample strobe |
| scan_start_i | input | 1 | Marks the strobe that opens a new scan |
| range_idx_i | input | 10 | Range cell of the sample |
| sample_i | input | 16 | Unsigned video amplitude |
| gain_new_i | input | 16 | Weight of the new sample, 16 fraction bits |
| gain_old_i | input | 16 | Weight of the old estimate, 16 fraction bits |
| thr_mult_i | input | 20 | Threshold multiplier, 4.16 fixed point |
| out_valid_o | output | 1 | Result valid |
| out_idx_o | output | 10 | Echoed range index |
| hit_o | output | 1 | Detection flag |
| thr_o | output | 16 | Threshold applied to the sample |
| est_o | output | 16 | Updated estimate written back |

## Verification
The first scan drives a gentle ramp of amplitudes over zeroed cells. Every sample there would exceed a zero threshold, so muted hits show whether arming waits for the second scan start. The second scan mixes ordinary clutter, a strong target, and a sample set exactly at its threshold. This separates a strict comparison from a non-strict one and shows whether the old estimate, not the new one, feeds the threshold. A burst to one cell on consecutive cycles exposes a missing read-after-write bypass. Extreme multipliers and gains push both the threshold and the weighted sum into saturation. A clear pulse mid-run, with strobes offered during the sweep, shows whether the map really returns to zero and whether strobes in the sweep are dropped.

// File: rtl/cmap_cfar_pkg.sv
package cmap_cfar_pkg;
  localparam int SAMPLE_W = 16;
  localparam int FRAC_W   = 16;
  localparam int MULT_W   = 20;
  localparam int NCELLS   = 1024;
endpackage

// File: rtl/cmap_ram.sv
module cmap_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             we_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wr_data_i;
    rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/cmap_sweep.sv
module cmap_sweep #(
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          scan_start_i,
  output logic          clearing_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          armed_o
);
  logic          clearing_q;
  logic [AW-1:0] addr_q;
  logic [1:0]    scans_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clearing_q <= 1'b1;
      addr_q     <= '0;
    end else if (clear_i) begin
      clearing_q <= 1'b1;
      addr_q     <= '0;
    end else if (clearing_q) begin
      if (addr_q == AW'(DEPTH - 1)) clearing_q <= 1'b0;
      addr_q <= addr_q + 1'b1;
    end
  end

  // arm once one full scan has been gathered: second scan start after sweep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        scans_q <= '0;
    else if (clear_i || clearing_q)     scans_q <= '0;
    else if (scan_start_i && scans_q != 2'd2) scans_q <= scans_q + 1'b1;
  end

  assign clearing_o = clearing_q;
  assign wr_addr_o  = addr_q;
  assign armed_o    = (scans_q == 2'd2);

  p_sweep_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clearing_q) |-> $past(addr_q) == AW'(DEPTH - 1));
endmodule

// File: rtl/cmap_update.sv
module cmap_update #(
  parameter int SW = 16,
  parameter int FW = 16,
  parameter int MW = 20,
  localparam int PT = MW + SW,
  localparam int PE = FW + SW
) (
  input  logic [SW-1:0] sample_i,
  input  logic [SW-1:0] old_i,
  input  logic [FW-1:0] gain_new_i,
  input  logic [FW-1:0] gain_old_i,
  input  logic [MW-1:0] mult_i,
  input  logic          armed_i,
  output logic [SW-1:0] thr_o,
  output logic [SW-1:0] est_o,
  output logic          hit_o
);
  logic [PT-1:0] thr_full;
  logic [PE-1:0] p_new, p_old;
  logic [SW:0]   sum;

  assign thr_full = PT'(mult_i) * PT'(old_i);
  assign p_new    = PE'(gain_new_i) * PE'(sample_i);
  assign p_old    = PE'(gain_old_i) * PE'(old_i);

  generate
    if (PT - FW > SW) begin : g_thr_sat
      assign thr_o = (|thr_full[PT-1:FW+SW]) ? '1 : thr_full[FW+SW-1:FW];
    end else begin : g_thr_plain
      assign thr_o = SW'(thr_full[PT-1:FW]);
    end
  endgenerate

  assign sum   = {1'b0, p_new[PE-1:FW]} + {1'b0, p_old[PE-1:FW]};
  assign est_o = sum[SW] ? '1 : sum[SW-1:0];
  assign hit_o = armed_i && (sample_i > thr_o);
endmodule

// File: rtl/cmap_cfar.sv
module cmap_cfar
  import cmap_cfar_pkg::*;
#(
  parameter int SW      = SAMPLE_W,
  parameter int FW      = FRAC_W,
  parameter int MW      = MULT_W,
  parameter int NCELL   = NCELLS,
  localparam int AW     = $clog2(NCELL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          sample_valid_i,
  input  logic          scan_start_i,
  input  logic [AW-1:0] range_idx_i,
  input  logic [SW-1:0] sample_i,
  input  logic [FW-1:0] gain_new_i,
  input  logic [FW-1:0] gain_old_i,
  input  logic [MW-1:0] thr_mult_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_idx_o,
  output logic          hit_o,
  output logic [SW-1:0] thr_o,
  output logic [SW-1:0] est_o
);
  logic          clearing, armed, acc;
  logic [AW-1:0] clr_addr;
  logic [SW-1:0] rd_data, old_est, new_est, thr_c;
  logic          hit_c;

  logic          s1_valid_q;
  logic [AW-1:0] s1_idx_q;
  logic [SW-1:0] s1_sample_q;
  logic          byp_q;
  logic [SW-1:0] byp_est_q;

  assign acc = sample_valid_i && !clearing && !clear_i;

  cmap_sweep #(.DEPTH(NCELL)) i_sweep (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .scan_start_i (acc && scan_start_i),
    .clearing_o   (clearing),
    .wr_addr_o    (clr_addr),
    .armed_o      (armed)
  );

  cmap_ram #(.DEPTH(NCELL), .WIDTH(SW)) i_ram (
    .clk_i     (clk_i),
    .rd_addr_i (range_idx_i),
    .rd_data_o (rd_data),
    .we_i      (clearing || s1_valid_q),
    .wr_addr_i (clearing ? clr_addr : s1_idx_q),
    .wr_data_i (clearing ? '0 : new_est)
  );

  // bypass covers a read issued in the same cycle as the write to that cell
  assign old_est = byp_q ? byp_est_q : rd_data;

  cmap_update #(.SW(SW), .FW(FW), .MW(MW)) i_update (
    .sample_i   (s1_sample_q),
    .old_i      (old_est),
    .gain_new_i (gain_new_i),
    .gain_old_i (gain_old_i),
    .mult_i     (thr_mult_i),
    .armed_i    (armed),
    .thr_o      (thr_c),
    .est_o      (new_est),
    .hit_o      (hit_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q  <= 1'b0;
      s1_idx_q    <= '0;
      s1_sample_q <= '0;
      byp_q       <= 1'b0;
      byp_est_q   <= '0;
    end else begin
      s1_valid_q  <= acc;
      s1_idx_q    <= range_idx_i;
      s1_sample_q <= sample_i;
      byp_q       <= s1_valid_q && (s1_idx_q == range_idx_i);
      byp_est_q   <= new_est;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_idx_o   <= '0;
      hit_o       <= 1'b0;
      thr_o       <= '0;
      est_o       <= '0;
    end else begin
      out_valid_o <= s1_valid_q;
      out_idx_o   <= s1_idx_q;
      hit_o       <= s1_valid_q && hit_c;
      thr_o       <= thr_c;
      est_o       <= new_est;
    end
  end

  p_hit_with_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> out_valid_o);
  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(acc, 2));
  p_hit_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(armed));
  p_no_out_after_sweep_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !$past(clearing, 2));
endmodule

// File: tb/test_cmap_cfar.sv
`timescale 1ns/1ps
module test_cmap_cfar;
  localparam int NC = 1024;
  localparam int AW = 10;

  logic clk = 0, rst_n = 0, clear = 0, valid = 0, start = 0;
  logic [AW-1:0] idx = '0;
  logic [15:0] smp = '0, g_new = '0, g_old = '0;
  logic [19:0] mult = '0;
  logic out_valid, hit;
  logic [AW-1:0] out_idx;
  logic [15:0] thr, est;

  always #2.5 clk = ~clk;

  cmap_cfar i_cmap_cfar (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .sample_valid_i(valid),
    .scan_start_i(start), .range_idx_i(idx), .sample_i(smp),
    .gain_new_i(g_new), .gain_old_i(g_old), .thr_mult_i(mult),
    .out_valid_o(out_valid), .out_idx_o(out_idx), .hit_o(hit),
    .thr_o(thr), .est_o(est)
  );

  typedef struct {int idx; int thr; int est; int hit; int cyc; string note;} item_t;
  item_t q[$];
  int est_m [NC];
  int scans_m = 0;
  int cyc = 0, nchk = 0, nfail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(longint v);
    return (v > 65535) ? 65535 : int'(v);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) chk("R2 unexpected result", 1, 0);
      else begin
        item_t it;
        it = q.pop_front();
        chk({"R2 latency ", it.note}, cyc, it.cyc + 2);
        chk({"R2 index ", it.note}, int'(out_idx), it.idx);
        chk({"R3 threshold ", it.note}, int'(thr), it.thr);
        chk({"R5 estimate ", it.note}, int'(est), it.est);
        chk({"R4 hit ", it.note}, int'(hit), it.hit);
      end
    end
  end

  task automatic drive(int i, int s, bit st, bit exp_acc, string note);
    @(negedge clk);
    valid = 1; idx = AW'(i); smp = 16'(s); start = st;
    if (exp_acc) begin
      item_t it;
      int old;
      old = est_m[i];
      if (st && scans_m < 2) scans_m++;
      it.idx = i;
      it.thr = sat16((longint'(mult) * old) >>> 16);
      it.est = sat16(((longint'(g_new) * s) >>> 16) + ((longint'(g_old) * old) >>> 16));
      it.hit = (scans_m == 2 && s > it.thr) ? 1 : 0;
      it.cyc = cyc;
      it.note = note;
      est_m[i] = it.est;
      q.push_back(it);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid = 0; start = 0;
      idx = AW'(k * 37); smp = 16'(k * 911); // R8: noise on idle inputs
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NC; k++) est_m[k] = 0;
    scans_m = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset hit", int'(hit), 0);
    chk("R1 reset est", int'(est), 0);
    rst_n = 1;
    g_new = 16'd6554; g_old = 16'd58982; mult = 20'd196608; // 0.1 / 0.9, k = 3.0
    // R1: strobes during the reset sweep are dropped
    drive(4, 5000, 1, 0, "R1 strobe in sweep");
    idle(NC + 8);

    // scan A: every sample beats a zero threshold, hits muted (R7)
    for (int i = 0; i < 16; i++) drive(i, 1000 + 10 * i, i == 0, 1, "R7 first scan muted");
    idle(3);
    // scan B: armed; target on 7, equality on 3 (R4)
    for (int i = 0; i < 16; i++) begin
      int s;
      s = 1000 + 10 * i;
      if (i == 7) s = 20000;
      if (i == 3) s = sat16((longint'(mult) * est_m[3]) >>> 16);
      drive(i, s, i == 0, 1, i == 3 ? "R4 equal no hit" : "R7 second scan armed");
    end
    idle(3);
    // R6: same cell back to back
    drive(9, 30000, 0, 1, "R6 burst");
    drive(9, 30000, 0, 1, "R6 burst");
    drive(9, 500, 0, 1, "R6 burst");
    drive(10, 40000, 0, 1, "R6 burst");
    drive(9, 45000, 0, 1, "R6 burst");
    idle(3);
    // saturation of sum (R5) and threshold (R3)
    g_new = 16'hFFFF; g_old = 16'hFFFF; mult = 20'hFFFFF;
    drive(20, 60000, 0, 1, "R5 sum");
    drive(20, 65535, 0, 1, "R5 sum saturate");
    drive(20, 100, 0, 1, "R3 threshold saturate");
    idle(3);
    g_new = 16'd6554; g_old = 16'd58982; mult = 20'd131072;
    drive(11, 1200, 0, 1, "R8 untouched cell");
    idle(4);
    // R1: clear mid-run
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    model_clear();
    drive(9, 7000, 1, 0, "R1 strobe in clear sweep");
    idle(NC + 8);
    drive(9, 7000, 1, 1, "R1 estimate zeroed");
    drive(20, 300, 0, 1, "R1 estimate zeroed");
    idle(6);
    chk("R2 results drained", q.size(), 0);
    finish_run();
  end
endmodule